// File: doc/BRIEF.md
# Register-Mapped Factorial Accelerator

This block is a memory-mapped slave that works out the factorial of a 32-bit operand without holding up the host. The host writes the operand into a register. It then polls a busy flag until the flag clears. After that it reads the truncated result back from the same register.

The block multiplies once per clock and counts the operand down. The host sees the latency of the computation only through the busy flag.

An enable bit in the status register controls completion signalling. When the enable is set and a computation finishes, the block sends a one-cycle request on an output. A separate interrupt-status block latches that request as its interrupt bit 0.

The block also has two more registers. One is a fixed identification word. The other is a scratch register that reads back the inverse of the last value written to it.

The register port is single-cycle and has four parts: a write strobe, an address, write data and an access size in bytes. Reads have no side effects. Read data is a combinational function of the address and the size.

Top module: `fact_accel`

## Requirements
- R1: Offset 0x00 reads the constant 0x010000ED, and writes to it change nothing.
- R2: Offset 0x04 reads the bitwise complement of the last word written there.
- R3: A word write to offset 0x08 while idle loads the operand and, from the next cycle on, sets bit 0 of the status register at offset 0x20.
- R4: A write to offset 0x08 while bit 0 of the status register is set is dropped, and the running computation continues unaltered.
- R5: A computation on operand n ends max(n,1) cycles after the write. At that point the operand register holds n! truncated to 32 bits, and status bit 0 clears.
- R6: Operands 0 and 1 both give a result of 1.
- R7: Status bit 7 is an interrupt enable. A word write to 0x20 copies write-data bit 7 into it, and this holds whether the block is busy or idle.
- R8: `done_irq` is high for exactly the one cycle in which status bit 0 has just cleared. It goes high only if status bit 7 was set on the edge that finished the computation.
- R9: Any access whose size is not 4 bytes is ignored on write and reads back 0xFFFFFFFF.
- R10: After reset, the operand and status both read 0, and the scratch register reads 0xFFFFFFFF. An offset with no register behind it reads 0xFFFFFFFF.
- R11: While busy, a read of 0x08 returns the operand as written, not a partial product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for this cycle |
| addr | input | AW (8) | Byte offset of the access |
| acc_size | input | 4 | Access size in bytes; only 4 is accepted |
| wr_data | input | DW (32) | Write data |
| rd_data | output | DW (32) | Read data for addr/acc_size |
| done_irq | output | 1 | One-cycle completion interrupt request |

## Verification
A wrong countdown or accumulator shows up on the ports in one of two ways. Either the busy bit drops on the wrong cycle, or the result read from 0x08 is wrong on the first cycle after busy clears. The bench compares every clock, so an off-by-one latency is caught on the exact cycle it happens. A dropped-write fault that lets a busy-time write through shows up as a changed value at 0x08 on the very next cycle. A wrongly latched enable shows up as a missing or extra `done_irq` pulse on the completion cycle. Operands 12 and 13 test the truncation: 13! is the first factorial that overflows 32 bits.

// File: rtl/fact_accel.sv
module fact_accel #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [DW-1:0] ID_WORD = 32'h010000ED
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [3:0]    acc_size,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          done_irq
);
  localparam logic [AW-1:0] OFF_ID  = AW'(8'h00);
  localparam logic [AW-1:0] OFF_SCR = AW'(8'h04);
  localparam logic [AW-1:0] OFF_OP  = AW'(8'h08);
  localparam logic [AW-1:0] OFF_ST  = AW'(8'h20);
  localparam logic [DW-1:0] ONES    = '1;

  logic [DW-1:0] scratch, operand, acc, cnt;
  logic          busy, irq_en;

  wire word_ok = (acc_size == 4'd4);
  wire wr_ok   = wr_en && word_ok;
  wire last    = (cnt <= DW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch  <= '0;
      operand  <= '0;
      acc      <= '0;
      cnt      <= '0;
      busy     <= 1'b0;
      irq_en   <= 1'b0;
      done_irq <= 1'b0;
    end else begin
      done_irq <= 1'b0;
      if (wr_ok && addr == OFF_SCR) scratch <= wr_data;
      if (wr_ok && addr == OFF_ST)  irq_en  <= wr_data[7];
      if (busy) begin
        if (last) begin
          operand  <= acc;
          busy     <= 1'b0;
          done_irq <= irq_en;
        end else begin
          acc <= acc * cnt;
          cnt <= cnt - DW'(1);
        end
      end else if (wr_ok && addr == OFF_OP) begin
        operand <= wr_data;
        acc     <= DW'(1);
        cnt     <= wr_data;
        busy    <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = ONES;
    if (word_ok) begin
      case (addr)
        OFF_ID:  rd_data = ID_WORD;
        OFF_SCR: rd_data = ~scratch;
        OFF_OP:  rd_data = operand;
        OFF_ST:  rd_data = {{(DW-8){1'b0}}, irq_en, 6'b0, busy};
        default: rd_data = ONES;
      endcase
    end
  end

  p_id_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ok && addr == OFF_ID) |-> rd_data == ID_WORD);

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr == OFF_OP && !busy) |=> busy);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> $stable(operand));

  p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> ($fell(busy) && $past(irq_en)));

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  p_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !word_ok |-> rd_data == ONES);
endmodule

// File: tb/tb_fact_accel.sv
module tb_fact_accel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [3:0]  acc_size = 4'd4;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        done_irq;

  int vectors = 0;
  int misses  = 0;
  bit finished = 1'b0;

  fact_accel dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                  .acc_size(acc_size), .wr_data(wr_data), .rd_data(rd_data),
                  .done_irq(done_irq));

  always #4 clk = ~clk;

  // behavioural reference
  logic [31:0] m_scr, m_op, m_res;
  bit          m_busy, m_ie, m_irq;
  int          m_left;

  function automatic logic [31:0] fact32(input logic [31:0] n);
    longint p = 1;
    for (longint i = n; i > 1; i--) p = (p * i) & 64'hFFFF_FFFF;
    return p[31:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_scr = '0; m_op = '0; m_res = '0;
      m_busy = 0; m_ie = 0; m_irq = 0; m_left = 0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      m_irq = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_op = m_res; m_busy = 0; m_irq = m_ie;
        end
      end
      if (wr_en && acc_size == 4'd4) begin
        case (addr)
          8'h04: m_scr = wr_data;
          8'h08: if (!was_busy) begin
                   m_op = wr_data; m_res = fact32(wr_data); m_busy = 1;
                   m_left = (wr_data <= 1) ? 1 : int'(wr_data);
                 end
          8'h20: m_ie = wr_data[7];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [7:0] a, input logic [3:0] s);
    if (s != 4'd4) return 32'hFFFF_FFFF;
    case (a)
      8'h00: return 32'h010000ED;
      8'h04: return ~m_scr;
      8'h08: return m_op;
      8'h20: return {24'b0, m_ie, 6'b0, m_busy};
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic string tag(input logic [7:0] a, input logic [3:0] s);
    if (s != 4'd4) return "R9";
    case (a)
      8'h00: return "R1";
      8'h04: return "R2";
      8'h08: return "R5/R11";
      8'h20: return "R3/R7";
      default: return "R10";
    endcase
  endfunction

  task automatic compare();
    logic [31:0] e;
    e = exp_rd(addr, acc_size);
    vectors++;
    if (rd_data !== e) begin
      misses++;
      $display("FAIL %s addr=%h size=%0d rd_data=%h expected=%h",
               tag(addr, acc_size), addr, acc_size, rd_data, e);
    end
    vectors++;
    if (done_irq !== m_irq) begin
      misses++;
      $display("FAIL R8 done_irq=%b expected=%b", done_irq, m_irq);
    end
  endtask

  task automatic cyc(input bit we, input logic [7:0] a, input logic [31:0] d,
                     input logic [3:0] s);
    wr_en = we; addr = a; wr_data = d; acc_size = s;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    compare();
  endtask

  task automatic rd(input logic [7:0] a);
    cyc(1'b0, a, 32'h0, 4'd4);
  endtask

  task automatic run_op(input logic [31:0] n, input int extra);
    cyc(1'b1, 8'h08, n, 4'd4);
    for (int i = 0; i < ((n <= 1) ? 1 : int'(n)) + extra; i++)
      rd((i % 2 == 0) ? 8'h20 : 8'h08);
    rd(8'h08);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state and unmapped offset
    rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h20); rd(8'h10); rd(8'h84);
    // R2 scratch, R1 id write ignored
    cyc(1'b1, 8'h04, 32'h1234_5678, 4'd4); rd(8'h04);
    cyc(1'b1, 8'h00, 32'hDEAD_BEEF, 4'd4); rd(8'h00);
    // R9 non-word sizes
    cyc(1'b1, 8'h04, 32'hAAAA_5555, 4'd2); rd(8'h04);
    cyc(1'b0, 8'h04, 32'h0, 4'd8); cyc(1'b0, 8'h00, 32'h0, 4'd1);
    cyc(1'b1, 8'h08, 32'd4, 4'd1); rd(8'h20); rd(8'h08);
    // R7 enable on, R3/R5/R8/R11 with operand 5
    cyc(1'b1, 8'h20, 32'h80, 4'd4); rd(8'h20);
    cyc(1'b1, 8'h08, 32'd5, 4'd4); rd(8'h08); rd(8'h20);
    // R4 write while busy dropped
    cyc(1'b1, 8'h08, 32'd9, 4'd4); rd(8'h08);
    repeat (6) rd(8'h20);
    rd(8'h08);
    // R6 edge operands
    run_op(32'd0, 2);
    run_op(32'd1, 2);
    // R7 disable while busy -> no irq (R8)
    cyc(1'b1, 8'h08, 32'd12, 4'd4);
    cyc(1'b1, 8'h20, 32'h7F, 4'd4);
    repeat (14) rd(8'h20);
    rd(8'h08);
    // truncation, enable off
    run_op(32'd13, 2);
    cyc(1'b1, 8'h20, 32'hFFFF_FF80, 4'd4);
    run_op(32'd10, 2);
    // write on the completion edge is dropped (R4)
    cyc(1'b1, 8'h08, 32'd3, 4'd4); rd(8'h08); rd(8'h20);
    cyc(1'b1, 8'h08, 32'd7, 4'd4);
    repeat (3) rd(8'h08);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule